// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Core with Selectable Output Stage

This block is the storage and data path of a synchronous SRAM. A small array is split into byte lanes, each lane nine bits wide so that a parity bit travels with every byte. On each rising clock edge the block takes one command: a select flag, an address, two write strobes (one that writes every lane and one that writes only enabled lanes), per-lane enables and write data. A selected command is a write when either write strobe is low. Otherwise it is a read.

Read data leaves through one of two output paths, picked by a mode pin. In the bypass path the array word reaches the pins in the cycle right after the edge that captured the read. In the registered path it passes through one more clocked stage. The drive enable always follows the command held in the input register, one stage ahead of registered data. A deselect or write therefore cuts the bus at once, and the last read of a pipelined run needs one more read cycle behind it to be seen. An asynchronous active-low output enable can only take drive away.

A sleep request held high for two edges puts the core to sleep. While asleep it ignores commands, keeps the array and does not drive the bus. After wake-up, writes are refused for a fixed number of cycles while reads are served.

Top module: `sync_sram_core`

## Requirements
- R1: A selected command with `all_wr_n` low writes all lanes at `addr`, whatever `lane_wr_n` and `lane_en_n` are.
- R2: With `all_wr_n` high and `lane_wr_n` low, only lane i with `lane_en_n[i]` low is written. Lane i is bits [9i+8:9i] of `wdata` and `dq_out`.
- R3: With `all_wr_n` high, `lane_wr_n` low and every `lane_en_n` bit high, the command is a write that changes no lane.
- R4: A read returns every lane of the stored word, including a word written by the previous command.
- R5: With `flow_mode_n` low, a read captured at edge e drives `dq_oe` high and the word on `dq_out` during the cycle after edge e.
- R6: With `flow_mode_n` high, the word of a read captured at edge e is on `dq_out` after edge e+1. It is driven only if the command captured at edge e+1 is also a read.
- R7: In the cycle after an edge that captures a deselect or a write, `dq_oe` is low.
- R8: `oe_n` high forces `dq_oe` low at once, without a clock edge. `oe_n` low enables drive only in cycles that carry valid read data.
- R9: Once `sleep_req` is sampled high at two consecutive edges, commands at later edges are ignored and `dq_oe` stays low until wake-up. Array contents are kept.
- R10: From the first edge that samples `sleep_req` low after sleep, writes are refused at the following `REC_CYC` edges, while reads are served.
- R11: After reset `dq_oe` is low and no earlier read is pending in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sel | input | 1 | Command is addressed to this core |
| addr | input | ADDR_W | Word address |
| all_wr_n | input | 1 | Active-low write of all lanes |
| lane_wr_n | input | 1 | Active-low write of enabled lanes |
| lane_en_n | input | LANES | Active-low per-lane write enables |
| wdata | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| flow_mode_n | input | 1 | Low: bypass output path; high: registered output path |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Sleep request, active high |
| dq_out | output | LANES*LANE_W | Read data toward the pins |
| dq_oe | output | 1 | Pin driver enable |

## Verification
The two hardest situations to reach from the ports are the edges just around a sleep exit and the cut-off of a pipelined read. Around sleep exit, a write placed one edge too early or too late tells a correct recovery window from one that is off by one. A directed sequence counts edges from the rise of `sleep_req`: it puts writes on both entry edges, on sleeping edges, inside the recovery window and just after it, then reads every address back. For the pipelined cut-off, a directed run ends a read burst both with and without a trailing read. Random traffic then switches output mode, output enable and short sleep pulses, so these same edges occur again in many combinations.

// File: rtl/ssram_pkg.sv
// Shared definitions for the byte-lane SRAM core.
// Assumes: active-low write strobes; a selected non-write command is a read.
package ssram_pkg;

    // Output path selection, encoded as the level of the mode pin
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

    // True when either write strobe is asserted
    function automatic logic is_write(input logic all_wr_n, input logic lane_wr_n);
        return (!all_wr_n) || (!lane_wr_n);
    endfunction

endpackage

// File: rtl/ssram_lane_array.sv
// Storage array split into independent byte lanes.
// Assumes: one write port and one asynchronous read port; contents are not reset.
module ssram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when its enable is set
        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Asynchronous read of this lane
        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/ssram_sleep_ctl.sv
// Sleep entry and wake-up recovery control.
// Assumes: sleep_req is synchronous to clk; REC_CYC is the number of edges after
// the wake edge at which writes are refused.
module ssram_sleep_ctl #(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep,
    output logic wr_block
);
    localparam int CNT_W = $clog2(REC_CYC + 2);

    logic             req_seen;
    logic [CNT_W-1:0] rec_cnt;

    // Sleep begins when the request is seen at two consecutive edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            asleep   <= 1'b0;
        end else begin
            req_seen <= sleep_req;
            asleep   <= sleep_req && req_seen;
        end
    end

    // Recovery window counter loaded on the wake edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (asleep && !sleep_req) begin
            rec_cnt <= CNT_W'(REC_CYC);
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    assign wr_block = (rec_cnt != '0);

endmodule

// File: rtl/ssram_out_stage.sv
// Output path: bypass or registered data, with drive gating taken from the
// input-register command (single-cycle deselect) and the asynchronous enable.
// Assumes: cap_rd is the read flag captured at the last edge; arr_rdata is the
// array word at the captured address.
module ssram_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_mode_n,
    input  logic              oe_n,
    input  logic              asleep,
    input  logic              cap_rd,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    import ssram_pkg::*;

    out_mode_e         mode;
    logic              pipe_vld;
    logic [DATA_W-1:0] pipe_data;
    logic              rd_valid;

    // Output register stage for the registered path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_vld  <= 1'b0;
            pipe_data <= '0;
        end else begin
            pipe_vld  <= cap_rd;
            pipe_data <= arr_rdata;
        end
    end

    // Select data and decide whether this cycle carries valid read data
    always_comb begin
        mode = out_mode_e'(flow_mode_n);
        if (mode == OUT_FLOW) begin
            dq_out   = arr_rdata;
            rd_valid = cap_rd;
        end else begin
            dq_out   = pipe_data;
            rd_valid = cap_rd && pipe_vld;
        end
        dq_oe = rd_valid && !asleep && !oe_n;
    end

endmodule

// File: rtl/sync_sram_core.sv
// Top of the byte-lane SRAM core: command decode, input register, array,
// output stage and sleep control.
// Assumes: all command inputs are sampled on the rising edge; writes take
// effect at the capturing edge; reads use the word addressed at that edge.
module sync_sram_core #(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int REC_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    flow_mode_n,
    input  logic                    oe_n,
    input  logic                    sleep_req,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    import ssram_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    logic              slp_asleep;
    logic              slp_wr_block;
    logic              acc_sel;
    logic              wr_cmd;
    logic              rd_cmd;
    logic [LANES-1:0]  lane_we;
    logic              cap_rd;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] arr_rdata;

    // Decode the incoming command into read, write and lane enables
    always_comb begin
        acc_sel = cmd_sel && !slp_asleep;
        wr_cmd  = acc_sel && is_write(all_wr_n, lane_wr_n);
        rd_cmd  = acc_sel && !wr_cmd;
        if (!wr_cmd || slp_wr_block) begin
            lane_we = '0;
        end else if (!all_wr_n) begin
            lane_we = '1;
        end else begin
            lane_we = ~lane_en_n;
        end
    end

    // Input register holding the read flag and address of the last command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_rd   <= 1'b0;
            cap_addr <= '0;
        end else begin
            cap_rd   <= rd_cmd;
            cap_addr <= addr;
        end
    end

    ssram_sleep_ctl #(
        .REC_CYC (REC_CYC)
    ) u_slp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .asleep    (slp_asleep),
        .wr_block  (slp_wr_block)
    );

    ssram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk   (clk),
        .we    (lane_we),
        .waddr (addr),
        .wdata (wdata),
        .raddr (cap_addr),
        .rdata (arr_rdata)
    );

    ssram_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .flow_mode_n (flow_mode_n),
        .oe_n        (oe_n),
        .asleep      (slp_asleep),
        .cap_rd      (cap_rd),
        .arr_rdata   (arr_rdata),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

endmodule

// File: rtl/ssram_core_chk.sv
// Property checker for sync_sram_core, attached by bind.
// Assumes: connected to the top's ports and internal decode/sleep signals.
module ssram_core_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_sel,
    input logic             oe_n,
    input logic             flow_mode_n,
    input logic             wr_cmd,
    input logic             cap_rd,
    input logic             asleep,
    input logic             wr_block,
    input logic [LANES-1:0] lane_we,
    input logic             dq_oe
);

    // R8
    oe_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R7
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> !dq_oe);

    // R7
    desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_sel |=> !dq_oe);

    // R6
    pipe_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode_n && dq_oe) |-> (cap_rd && $past(cap_rd)));

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!dq_oe && lane_we == '0));

    // R10
    recover_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> (lane_we == '0));

endmodule

bind sync_sram_core ssram_core_chk #(
    .LANES (LANES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_sel     (cmd_sel),
    .oe_n        (oe_n),
    .flow_mode_n (flow_mode_n),
    .wr_cmd      (wr_cmd),
    .cap_rd      (cap_rd),
    .asleep      (slp_asleep),
    .wr_block    (slp_wr_block),
    .lane_we     (lane_we),
    .dq_oe       (dq_oe)
);

// File: tb/sim_sync_sram_core.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a reference model built from the requirements.
module sim_sync_sram_core;
    localparam int ADDR_W  = 6;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int REC_CYC = 4;
    localparam int DW      = LANES * LANE_W;
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_sel;
    logic [ADDR_W-1:0] addr;
    logic              all_wr_n;
    logic              lane_wr_n;
    logic [LANES-1:0]  lane_en_n;
    logic [DW-1:0]     wdata;
    logic              flow_mode_n;
    logic              oe_n;
    logic              sleep_req;
    logic [DW-1:0]     dq_out;
    logic              dq_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference state
    logic [DW-1:0]     m_mem [DEPTH];
    logic              m_crd, m_pvld, m_seen, m_asleep;
    logic [ADDR_W-1:0] m_caddr;
    logic [DW-1:0]     m_pdata;
    int                m_rec;

    always #10 clk = ~clk;

    sync_sram_core #(
        .ADDR_W (ADDR_W), .LANES (LANES), .LANE_W (LANE_W), .REC_CYC (REC_CYC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cmd_sel (cmd_sel), .addr (addr),
        .all_wr_n (all_wr_n), .lane_wr_n (lane_wr_n), .lane_en_n (lane_en_n),
        .wdata (wdata), .flow_mode_n (flow_mode_n), .oe_n (oe_n),
        .sleep_req (sleep_req), .dq_out (dq_out), .dq_oe (dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 36'h0_1357_9BD + salt * 36'h0_2468_ACE + 36'h5A5);
    endfunction

    function automatic logic exp_oe();
        logic v;
        v = flow_mode_n ? (m_crd && m_pvld) : m_crd;
        return v && !m_asleep && !oe_n;
    endfunction

    function automatic logic [DW-1:0] exp_data();
        return flow_mode_n ? m_pdata : m_mem[m_caddr];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " drive"}, 64'(dq_oe), 64'(exp_oe()));
        if (exp_oe() && dq_oe) check({tag, " data"}, 64'(dq_out), 64'(exp_data()));
    endtask

    // Advance the model by one edge from the present inputs
    task automatic model_edge();
        logic sel_ok, wr, rd, nsl;
        if (!rst_n) begin
            m_crd = 0; m_pvld = 0; m_pdata = '0; m_caddr = '0;
            m_seen = 0; m_asleep = 0; m_rec = 0;
            return;
        end
        sel_ok = cmd_sel && !m_asleep;
        wr = sel_ok && (!all_wr_n || !lane_wr_n);
        rd = sel_ok && !wr;
        m_pdata = m_mem[m_caddr];
        m_pvld = m_crd;
        m_crd = rd;
        m_caddr = addr;
        if (wr && m_rec == 0) begin
            for (int l = 0; l < LANES; l++)
                if (!all_wr_n || !lane_en_n[l])
                    m_mem[addr][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
        end
        nsl = sleep_req && m_seen;
        if (m_asleep && !sleep_req) m_rec = REC_CYC;
        else if (m_rec > 0) m_rec--;
        m_seen = sleep_req;
        m_asleep = nsl;
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic s, input logic gw, input logic bw,
                       input logic [LANES-1:0] en, input int a, input logic [DW-1:0] d);
        cmd_sel = s; all_wr_n = gw; lane_wr_n = bw; lane_en_n = en;
        addr = ADDR_W'(a); wdata = d;
    endtask

    task automatic rd(input int a);
        cmd(1, 1, 1, 4'hF, a, '0);
    endtask

    task automatic idle();
        cmd(0, 1, 1, 4'hF, 0, '0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] old;
        void'($urandom(32'h00C0FFEE));
        rst_n = 0; flow_mode_n = 0; oe_n = 0; sleep_req = 0;
        idle();
        for (int a = 0; a < DEPTH; a++) m_mem[a] = 'x;
        @(negedge clk);
        step(); step(); step();
        rst_n = 1;
        // R11: reset leaves no drive
        check("R11 reset drive", 64'(dq_oe), 64'h0);

        // Fill the array with full-word writes (R1), bus off meanwhile (R7)
        for (int a = 0; a < DEPTH; a++) begin
            cmd(1, 0, 1, 4'hF, a, pat(a, 0));
            step();
            check_outputs("R7 write cycle");
        end
        // Flow-through reads, latency one edge (R5, R4)
        for (int a = 0; a < 8; a++) begin
            rd(a); step();
            check("R5 flow drive", 64'(dq_oe), 64'h1);
            check("R4 flow data", 64'(dq_out), 64'(pat(a, 0)));
        end
        // R2: byte write of lane 2 only
        old = pat(5, 0);
        cmd(1, 1, 0, 4'b1011, 5, pat(99, 7)); step();
        check("R7 byte write drive", 64'(dq_oe), 64'h0);
        rd(5); step();
        check("R2 lane2 only", 64'(dq_out),
              64'({old[35:27], pat(99, 7)[26:18], old[17:0]}));
        // R3: byte write with no lane enabled changes nothing
        old = m_mem[9];
        cmd(1, 1, 0, 4'hF, 9, pat(3, 3)); step();
        check("R3 write none drive", 64'(dq_oe), 64'h0);
        rd(9); step();
        check("R3 word unchanged", 64'(dq_out), 64'(old));
        // R1: global write ignores lane enables; R4 read-after-write
        cmd(1, 0, 0, 4'hF, 12, pat(12, 5)); step();
        rd(12); step();
        check("R1 all lanes", 64'(dq_out), 64'(pat(12, 5)));
        check("R4 raw drive", 64'(dq_oe), 64'h1);

        // R8: asynchronous enable while a read is valid
        rd(12);
        #2 oe_n = 1; #1;
        check("R8 oe high async", 64'(dq_oe), 64'h0);
        oe_n = 0; #1;
        check("R8 oe low restores", 64'(dq_oe), 64'h1);
        step();

        // Pipelined mode: SCD cut and dummy read (R6)
        idle(); step();
        flow_mode_n = 1;
        idle(); step();
        rd(20); step();
        check("R6 first pipe edge off", 64'(dq_oe), 64'h0);
        rd(21); step();
        check("R6 pipe drive", 64'(dq_oe), 64'h1);
        check("R6 pipe data", 64'(dq_out), 64'(pat(20, 0)));
        rd(22); step();
        check("R6 pipe data2", 64'(dq_out), 64'(pat(21, 0)));
        idle(); step();
        check("R6 deselect cuts last read", 64'(dq_oe), 64'h0);
        rd(30); step();
        rd(31); step();
        rd(31); step();
        check("R6 dummy read shows word", 64'(dq_out), 64'(pat(31, 0)));
        check("R6 dummy read drive", 64'(dq_oe), 64'h1);
        cmd(1, 0, 1, 4'hF, 33, pat(33, 1)); step();
        check("R7 write after read off", 64'(dq_oe), 64'h0);
        idle(); step();

        // Sleep entry, sleep, wake, recovery (R9, R10)
        flow_mode_n = 0;
        sleep_req = 1;
        cmd(1, 0, 1, 4'hF, 40, pat(40, 2)); step();   // accepted
        cmd(1, 0, 1, 4'hF, 41, pat(41, 2)); step();   // accepted, sleep begins
        check("R9 asleep no drive", 64'(dq_oe), 64'h0);
        for (int i = 0; i < 4; i++) begin
            cmd(1, 0, 1, 4'hF, 42, pat(42, 9)); step();
            check("R9 sleeping write ignored drive", 64'(dq_oe), 64'h0);
            rd(40); step();
            check("R9 sleeping read no drive", 64'(dq_oe), 64'h0);
        end
        sleep_req = 0;
        rd(40); step();                                  // wake edge, ignored
        check("R9 wake edge no drive", 64'(dq_oe), 64'h0);
        cmd(1, 0, 1, 4'hF, 43, pat(43, 9)); step();      // refused
        rd(41); step();
        check("R10 read in recovery", 64'(dq_out), 64'(pat(41, 2)));
        check("R10 read drive", 64'(dq_oe), 64'h1);
        cmd(1, 0, 1, 4'hF, 44, pat(44, 9)); step();      // refused
        cmd(1, 0, 1, 4'hF, 45, pat(45, 9)); step();      // last refused edge
        cmd(1, 0, 1, 4'hF, 46, pat(46, 9)); step();      // accepted
        for (int a = 40; a <= 46; a++) begin
            rd(a); step();
            check(a == 42 ? "R9 contents kept" : "R10 recovery window",
                  64'(dq_out), 64'(m_mem[a]));
        end
        check("R10 late write landed", 64'(m_mem[46]), 64'(pat(46, 9)));
        check("R10 early write refused", 64'(m_mem[45]), 64'(pat(45, 0)));

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (i % 250 == 0) flow_mode_n = ~flow_mode_n;
            oe_n = ($urandom_range(0, 19) == 0);
            sleep_req = (i % 700 > 690);
            if (r < 15) idle();
            else if (r < 55) rd(int'($urandom_range(0, DEPTH - 1)));
            else if (r < 70) cmd(1, 0, 1, 4'($urandom), int'($urandom_range(0, DEPTH - 1)),
                                 DW'({$urandom, $urandom}));
            else cmd(1, 1, 0, 4'($urandom), int'($urandom_range(0, DEPTH - 1)),
                     DW'({$urandom, $urandom}));
            step();
            check_outputs(flow_mode_n ? "R6 random" : "R5 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule